// File: doc/BRIEF.md
# UART Line Status and Interrupt Controller

This block turns the raw state of one UART channel into the line status byte, the interrupt identification byte and a single interrupt request line. It sits beside the channel's transmit and receive FIFOs and the serial shifters, and reads their occupancy counts, the shifter busy flag and the error flags that travel with each received character. Software reaches it through three access strobes: a line status read, an interrupt status read, and a transmit holding write.

Two interrupt styles are supported. In interrupt mode, each enabled source raises the request line. The receive source is a pure level compare against a selectable trigger threshold. The transmit source is a latched event. Line errors take precedence over both. In polled mode, all four low enable bits are zero. No request is raised and the interrupt status reads "none pending", while the line status byte keeps tracking the FIFOs so that software can poll it. There is no streaming data path: every pin is a plain control or status signal, so no valid/ready back-pressure applies.

Top module: `uart_stat_irq`

## Requirements
- R1: Line status bit 0 (data ready) is 1 exactly while the receive count is non-zero.
- R2: Line status bits 2, 3 and 4 show the head character's parity (`rx_head_err[0]`), framing (`rx_head_err[1]`) and break (`rx_head_err[2]`) flags while the receive FIFO is non-empty, and read 0 when it is empty.
- R3: Line status bit 1 (overrun) latches on an `rx_overrun` pulse and clears on a clock edge with `lsr_rd` high. A new overrun in the same cycle wins.
- R4: Line status bit 5 is 1 when the transmit count is zero. Bit 6 is 1 only when the transmit count is zero and `tsr_busy` is low.
- R5: Line status bit 7 sets on the edge where a character with any error flag is pushed. An `lsr_rd` clears it only if no error-carrying entry remains after that edge's push and pop.
- R6: The receive source is pending while the FIFO count is at least the trigger level. `rx_trig_sel` values 0, 1, 2 and 3 select 1, 4, 8 and 14 bytes, and `fifo_en` low forces a level of 1. The source drops with no register read.
- R7: The transmit source latches one cycle after the transmit count goes from non-zero to zero. A `thr_wr` clears it, and so does an `isr_rd` while it is the reported source. A clear wins over a set in the same cycle.
- R8: `isr[3:0]` reports the highest enabled pending source. Line error (enable bit 2, active when bit 1, 2, 3 or 4 of the line status is set) reads 4'b0110. Receive (enable bit 0) reads 4'b0100. Transmit (enable bit 1) reads 4'b0010. When nothing is pending it reads 4'b0001.
- R9: `irq` is high exactly when some enabled source is pending. With `ier[3:0]` all zero (polled mode), `irq` stays low while the line status keeps updating.
- R10: `isr[7:6]` both equal `fifo_en`, and `isr[5:4]` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| ier | input | 4 | Interrupt enables: 0 receive, 1 transmit, 2 line error, 3 unused here |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tsr_busy | input | 1 | Transmit shift register holds a character |
| rx_push | input | 1 | A character enters the receive FIFO |
| rx_push_err | input | 3 | Error flags of the pushed character {break, framing, parity} |
| rx_pop | input | 1 | The head character leaves the receive FIFO |
| rx_head_err | input | 3 | Error flags of the head character {break, framing, parity} |
| rx_overrun | input | 1 | Overrun pulse from the receiver |
| lsr_rd | input | 1 | Line status read strobe |
| isr_rd | input | 1 | Interrupt status read strobe |
| thr_wr | input | 1 | Transmit holding write strobe |
| lsr | output | 8 | Line status byte |
| isr | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-entry depth and the 1/4/8/14 trigger table. At that depth a random fill drives the receive count past the top threshold of 14 and back to empty, so every trigger crossing, both sides of each threshold and the full-FIFO case are reached. Error-flag density and enable patterns vary by phase: receive-only, transmit-only, all-enabled, polled and random. This makes priority conflicts, same-cycle set/clear races and the conditional clear of bit 7 occur many times.

// File: rtl/uls_pkg.sv
package uls_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_TX   = 3'b001,
    SRC_RX   = 3'b010,
    SRC_LS   = 3'b011
  } src_e;
endpackage

// File: rtl/uls_line_status.sv
module uls_line_status #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tsr_busy,
  input  logic             rx_push,
  input  logic [2:0]       rx_push_err,
  input  logic             rx_pop,
  input  logic [2:0]       rx_head_err,
  input  logic             rx_overrun,
  input  logic             lsr_rd,
  output logic [7:0]       lsr,
  output logic             ls_err
);
  logic             ovr_q;
  logic             fifo_err_q;
  logic [CNT_W-1:0] err_cnt;
  logic [CNT_W-1:0] err_nxt;
  logic             inc, dec;
  logic             rx_nonempty, tx_empty;
  logic [2:0]       head_vis;

  assign rx_nonempty = (rx_count != '0);
  assign tx_empty    = (tx_count == '0);
  assign head_vis    = rx_nonempty ? rx_head_err : 3'b000;

  // error-carrying entries currently held in the receive FIFO
  assign inc     = rx_push && (rx_push_err != 3'b000);
  assign dec     = rx_pop && rx_nonempty && (rx_head_err != 3'b000);
  assign err_nxt = err_cnt + {{(CNT_W-1){1'b0}}, inc} - {{(CNT_W-1){1'b0}}, dec};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt    <= '0;
      ovr_q      <= 1'b0;
      fifo_err_q <= 1'b0;
    end else begin
      err_cnt <= err_nxt;
      if (rx_overrun)  ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
      if (inc)                            fifo_err_q <= 1'b1;
      else if (lsr_rd && err_nxt == '0)   fifo_err_q <= 1'b0;
    end
  end

  assign lsr    = {fifo_err_q, tx_empty && !tsr_busy, tx_empty, head_vis, ovr_q, rx_nonempty};
  assign ls_err = ovr_q || (head_vis != 3'b000);

  a_r3_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[1] && !lsr_rd) |=> lsr[1]);
  a_r3_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> lsr[1]);
  a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_push_err != 3'b000) |=> lsr[7]);
  a_r5_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[7] && !lsr_rd) |=> lsr[7]);
endmodule

// File: rtl/uls_irq_ctrl.sv
module uls_irq_ctrl
  import uls_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [3:0]       ier,
  input  logic [1:0]       rx_trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             ls_err,
  input  logic             isr_rd,
  input  logic             thr_wr,
  output logic [7:0]       isr,
  output logic             irq
);
  localparam int NLVL = 4;
  localparam int TRIG_ARR [NLVL] = '{TRIG_0, TRIG_1, TRIG_2, TRIG_3};

  logic [CNT_W-1:0] lvl_tab [NLVL];
  logic [CNT_W-1:0] trig_lvl;
  logic             tx_nz_q, tx_pend_q;
  logic             ls_act, rx_act, tx_act;
  src_e             src;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_tab[g] = CNT_W'(TRIG_ARR[g]);
  end

  assign trig_lvl = fifo_en ? lvl_tab[rx_trig_sel] : CNT_W'(1);

  assign ls_act = ier[2] && ls_err;
  assign rx_act = ier[0] && (rx_count >= trig_lvl);
  assign tx_act = ier[1] && tx_pend_q;

  always_comb begin
    if (ls_act)      src = SRC_LS;
    else if (rx_act) src = SRC_RX;
    else if (tx_act) src = SRC_TX;
    else             src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_nz_q   <= 1'b0;
      tx_pend_q <= 1'b0;
    end else begin
      tx_nz_q <= (tx_count != '0);
      if (thr_wr || (isr_rd && src == SRC_TX)) tx_pend_q <= 1'b0;
      else if (tx_nz_q && tx_count == '0)      tx_pend_q <= 1'b1;
    end
  end

  assign isr = {fifo_en, fifo_en, 2'b00, src, src == SRC_NONE};
  assign irq = (src != SRC_NONE);

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !tx_pend_q);
  a_r9_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'b0000) |-> (!irq && isr[0]));
  a_r6_rx_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[0] && !ls_act && rx_count >= trig_lvl) |-> (isr[3:1] == SRC_RX));
  a_r8_none_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !isr[0]);
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq #(
  parameter int DEPTH  = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [3:0]       ier,
  input  logic [1:0]       rx_trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tsr_busy,
  input  logic             rx_push,
  input  logic [2:0]       rx_push_err,
  input  logic             rx_pop,
  input  logic [2:0]       rx_head_err,
  input  logic             rx_overrun,
  input  logic             lsr_rd,
  input  logic             isr_rd,
  input  logic             thr_wr,
  output logic [7:0]       lsr,
  output logic [7:0]       isr,
  output logic             irq
);
  logic ls_err;

  uls_line_status #(.CNT_W(CNT_W)) u_ls (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .tsr_busy(tsr_busy), .rx_push(rx_push), .rx_push_err(rx_push_err),
    .rx_pop(rx_pop), .rx_head_err(rx_head_err), .rx_overrun(rx_overrun),
    .lsr_rd(lsr_rd), .lsr(lsr), .ls_err(ls_err)
  );

  uls_irq_ctrl #(.CNT_W(CNT_W), .TRIG_0(TRIG_0), .TRIG_1(TRIG_1),
                 .TRIG_2(TRIG_2), .TRIG_3(TRIG_3)) u_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier),
    .rx_trig_sel(rx_trig_sel), .rx_count(rx_count), .tx_count(tx_count),
    .ls_err(ls_err), .isr_rd(isr_rd), .thr_wr(thr_wr), .isr(isr), .irq(irq)
  );

  a_r4_shifter_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_busy |-> !lsr[6]);
  a_r9_irq_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[0] == !irq));
endmodule

// File: tb/uart_stat_irq_bench.sv
`timescale 1ns/1ps
module uart_stat_irq_bench;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic fifo_en = 1;
  logic [3:0] ier = 0;
  logic [1:0] rx_trig_sel = 0;
  logic [CW-1:0] rx_count = 0, tx_count = 0;
  logic tsr_busy = 0, rx_push = 0, rx_pop = 0, rx_overrun = 0;
  logic [2:0] rx_push_err = 0, rx_head_err = 0;
  logic lsr_rd = 0, isr_rd = 0, thr_wr = 0;
  logic [7:0] lsr, isr;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  bit  m_ovr, m_fe, m_txp, m_txnz;
  int  m_errs;
  bit [2:0] q[$];
  int  txc;

  uart_stat_irq u_uart_stat_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier),
    .rx_trig_sel(rx_trig_sel), .rx_count(rx_count), .tx_count(tx_count),
    .tsr_busy(tsr_busy), .rx_push(rx_push), .rx_push_err(rx_push_err),
    .rx_pop(rx_pop), .rx_head_err(rx_head_err), .rx_overrun(rx_overrun),
    .lsr_rd(lsr_rd), .isr_rd(isr_rd), .thr_wr(thr_wr),
    .lsr(lsr), .isr(isr), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int trig();
    int t [4] = '{1, 4, 8, 14};
    return fifo_en ? t[rx_trig_sel] : 1;
  endfunction

  function automatic bit [2:0] head();
    return (q.size() != 0) ? q[0] : 3'b000;
  endfunction

  function automatic int exp_lsr();
    bit e = (q.size() == 0);
    bit te = (txc == 0);
    return {m_fe, te && !tsr_busy, te, head(), m_ovr, !e};
  endfunction

  // returns code 3,2,1 or 0
  function automatic int exp_src();
    if (ier[2] && (m_ovr || head() != 0)) return 3;
    if (ier[0] && q.size() >= trig()) return 2;
    if (ier[1] && m_txp) return 1;
    return 0;
  endfunction

  task automatic compare();
    int s = exp_src();
    int l = exp_lsr();
    chk("R1 data ready", lsr[0], l[0]);
    chk("R2 head flags", lsr[4:2], (l >> 2) & 7);
    chk("R3 overrun", lsr[1], l[1]);
    chk("R4 tx empty bits", lsr[6:5], (l >> 5) & 3);
    chk("R5 fifo error", lsr[7], l[7]);
    chk("R8 isr id", isr[3:0], (s == 0) ? 1 : (s << 1));
    chk("R9 irq", irq, s != 0);
    chk("R10 isr top", isr[7:4], {fifo_en, fifo_en, 2'b00});
    if (ier == 4'b0001) chk("R6 rx level irq", irq, q.size() >= trig());
    if (ier == 4'b0010) chk("R7 tx latch irq", irq, m_txp);
    if (ier == 4'b0000) chk("R9 polled quiet", irq, 0);
  endtask

  // reference update at a clock edge, using values held during that cycle
  task automatic model_edge();
    bit inc = rx_push && (rx_push_err != 0);
    bit dec = rx_pop && (q.size() != 0) && (head() != 0);
    int src = exp_src();
    m_errs = m_errs + inc - dec;
    if (inc) m_fe = 1; else if (lsr_rd && m_errs == 0) m_fe = 0;
    if (rx_overrun) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
    if (thr_wr || (isr_rd && src == 1)) m_txp = 0;
    else if (m_txnz && txc == 0) m_txp = 1;
    m_txnz = (txc != 0);
  endtask

  task automatic apply_fifo();
    if (rx_pop && q.size() != 0) void'(q.pop_front());
    if (rx_push && q.size() < DEPTH) q.push_back(rx_push_err);
    if (thr_wr && txc < DEPTH) txc++;
    else if (!thr_wr && txc > 0 && ($urandom % 3 == 0)) txc--;
    rx_count = CW'(q.size());
    rx_head_err = head();
    tx_count = CW'(txc);
  endtask

  task automatic stimulate(int phase, int fill_bias, int err_pct);
    rx_push = (q.size() < DEPTH) && ($urandom % 100 < fill_bias);
    rx_push_err = ($urandom % 100 < err_pct) ? 3'($urandom % 8) : 3'b000;
    rx_pop = ($urandom % 100 < 100 - fill_bias);
    rx_overrun = ($urandom % 100 < err_pct / 4);
    lsr_rd = ($urandom % 8 == 0);
    isr_rd = ($urandom % 6 == 0);
    thr_wr = ($urandom % 100 < ((phase == 1) ? 20 : 35));
    tsr_busy = ($urandom % 3 == 0);
    if ($urandom % 64 == 0) rx_trig_sel = 2'($urandom);
    if ($urandom % 128 == 0) fifo_en = ~fifo_en;
    if (phase == 4 && $urandom % 32 == 0) ier = 4'($urandom);
  endtask

  initial begin
    #50000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R4 reset lsr", lsr, 8'h60);
    chk("R8 reset isr", isr, 8'hC1);
    chk("R9 reset irq", irq, 0);
    for (int ph = 0; ph < 5; ph++) begin
      ier = (ph == 0) ? 4'b0001 : (ph == 1) ? 4'b0010 :
            (ph == 2) ? 4'b0111 : (ph == 3) ? 4'b0000 : 4'b0101;
      for (int n = 0; n < 3000; n++) begin
        int bias = ((n / 250) % 2 == 0) ? 70 : 30;
        @(posedge clk);
        model_edge();
        #1;
        apply_fifo();
        stimulate(ph, bias, (ph == 0 || ph == 1) ? 0 : 15);
        @(negedge clk);
        compare();
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule